// File: doc/BRIEF.md
# Transmit DMA Sequencer

This block moves a block of bytes from memory to a serial transmitter without processor involvement. Software writes a 24-bit start address and a 16-bit byte count. It then posts a transmit command. The sequencer reads one byte from memory and hands that byte to the transmitter. It waits until the transmitter accepts the byte, and only then reads the next one. When the count reaches zero, the block goes back to idle and can raise a transmit interrupt.

Commands pass through a single pending slot. A posted command stays pending until the sequencer is idle and takes it. While a command is pending, further commands are dropped and the status outputs are marked not valid. When a transfer finishes, the address register holds the address of the last byte sent plus one, so software can read back how far the transfer got.

Top module: `txdma_seq`

## Requirements
- R1: After reset the block is idle (`tx_idle`=1). No command is pending, `stat_valid`=1, `tx_irq`=0, `cur_addr`=0, `cur_cnt`=0, and neither `mem_req` nor `tx_valid` is asserted.
- R2: Address and count writes take effect only while the block is idle with no command pending. Writes made during a transfer are ignored.
- R3: A `cmd_wr` with no command pending sets `cmd_pending` and clears `stat_valid`. A `cmd_wr` made while a command is pending is ignored. A pending command is taken one cycle after the block is idle, which clears `cmd_pending`.
- R4: Command code 2'b01 starts a transfer only if both the address and the count have been written since the last transfer started. Otherwise the command is taken and has no effect. Any other code except 2'b10 is taken and has no effect.
- R5: In a transfer, `mem_req` is held with `mem_addr` equal to `cur_addr` until `mem_rvalid`. The next read starts only after the transmitter has accepted the previous byte.
- R6: A fetched byte is presented on `tx_data` with `tx_valid` held until `tx_rdy`. `mem_req` and `tx_valid` are never high together.
- R7: Each byte accepted by the transmitter increments `cur_addr` by one (wrapping at 24 bits) and decrements `cur_cnt` by one.
- R8: At the end of a transfer, `cur_addr` equals the start address plus the count (mod 2^24), `cur_cnt` is 0, and the block is idle.
- R9: A transmit command with a loaded count of zero completes at once. It issues no memory read, leaves `cur_addr` unchanged, and sets the interrupt when enabled.
- R10: `tx_irq` is set at completion only if `irq_en` is high. It stays set until command code 2'b10 is taken.
- R11: `tx_idle` is low for the whole of a transfer and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_wr | input | 1 | Load start address |
| addr_in | input | 24 | Start address value |
| cnt_wr | input | 1 | Load byte count |
| cnt_in | input | 16 | Byte count value |
| cmd_wr | input | 1 | Post a command |
| cmd_op | input | 2 | Command code: 01 transmit, 10 clear interrupt |
| irq_en | input | 1 | Transmit interrupt enable |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 24 | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| tx_valid | output | 1 | Byte offered to transmitter |
| tx_data | output | 8 | Byte to transmit |
| tx_rdy | input | 1 | Transmitter accepts byte |
| tx_idle | output | 1 | Transmitter-ready status (no transfer running) |
| cmd_pending | output | 1 | A command waits to be taken |
| stat_valid | output | 1 | Status outputs are valid |
| cur_addr | output | 24 | Current address register |
| cur_cnt | output | 16 | Remaining byte count |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The hardest case to reach is a command posted while a transfer is running. That command has to stay pending, a second command has to be dropped, and register writes have to be ignored, all in the same window. The stimulus slows the transmitter handshake so that a transfer lasts long enough. It waits for the first memory request. Then, inside that window, it writes a new address, posts a transmit command and posts a clear-interrupt command. Afterwards the bench checks the final address, the interrupt state and the number of bytes received.

// File: rtl/txdma_seq.sv
module txdma_seq #(
  parameter int AW = 24,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_wr,
  input  logic [AW-1:0] addr_in,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_in,
  input  logic          cmd_wr,
  input  logic [1:0]    cmd_op,
  input  logic          irq_en,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_rdy,
  output logic          tx_idle,
  output logic          cmd_pending,
  output logic          stat_valid,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output logic          tx_irq
);
  localparam logic [1:0] OP_XMIT = 2'b01;
  localparam logic [1:0] OP_CLRI = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_SEND} st_t;

  st_t           st;
  logic [1:0]    op_q;
  logic          a_ld, c_ld;
  logic [DW-1:0] byte_q;

  wire idle  = (st == S_IDLE);
  wire take  = cmd_pending && idle;
  wire go    = take && (op_q == OP_XMIT) && a_ld && c_ld;
  wire load  = idle && !cmd_pending;
  wire last  = (cur_cnt == CW'(1));

  assign mem_req    = (st == S_FETCH);
  assign mem_addr   = cur_addr;
  assign tx_valid   = (st == S_SEND);
  assign tx_data    = byte_q;
  assign tx_idle    = idle;
  assign stat_valid = !cmd_pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      op_q        <= '0;
      cmd_pending <= 1'b0;
      a_ld        <= 1'b0;
      c_ld        <= 1'b0;
      cur_addr    <= '0;
      cur_cnt     <= '0;
      byte_q      <= '0;
      tx_irq      <= 1'b0;
    end else begin
      if (cmd_wr && !cmd_pending) begin
        cmd_pending <= 1'b1;
        op_q        <= cmd_op;
      end else if (take) begin
        cmd_pending <= 1'b0;
      end

      if (load && addr_wr) begin
        cur_addr <= addr_in;
        a_ld     <= 1'b1;
      end
      if (load && cnt_wr) begin
        cur_cnt <= cnt_in;
        c_ld    <= 1'b1;
      end

      if (take && op_q == OP_CLRI) tx_irq <= 1'b0;

      if (go) begin
        a_ld <= 1'b0;
        c_ld <= 1'b0;
        if (cur_cnt == '0) begin
          if (irq_en) tx_irq <= 1'b1;
        end else begin
          st <= S_FETCH;
        end
      end

      case (st)
        S_FETCH: if (mem_rvalid) begin
          byte_q <= mem_rdata;
          st     <= S_SEND;
        end
        S_SEND: if (tx_rdy) begin
          cur_addr <= cur_addr + AW'(1);
          cur_cnt  <= cur_cnt - CW'(1);
          if (last) begin
            st <= S_IDLE;
            if (irq_en) tx_irq <= 1'b1;
          end else begin
            st <= S_FETCH;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module txdma_seq_chk #(
  parameter int AW = 24,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_en,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rvalid,
  input logic          tx_valid,
  input logic [DW-1:0] tx_data,
  input logic          tx_rdy,
  input logic          tx_idle,
  input logic          cmd_pending,
  input logic [AW-1:0] cur_addr,
  input logic [CW-1:0] cur_cnt,
  input logic          tx_irq
);
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  a_r5_fetch_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) && $past(tx_valid) |-> $past(tx_rdy));

  a_r6_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_rdy |=> tx_valid && $stable(tx_data));

  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && tx_valid));

  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_rdy |=> cur_addr == AW'($past(cur_addr) + 1'b1)
                           && cur_cnt == CW'($past(cur_cnt) - 1'b1));

  a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_irq) |-> $past(irq_en));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> !mem_req && !tx_valid);

  a_r3_pending_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pending && !tx_idle |=> cmd_pending);
endmodule

bind txdma_seq txdma_seq_chk #(.AW(AW), .CW(CW), .DW(DW)) u_chk (.*);

// File: tb/txdma_seq_test.sv
module txdma_seq_test;
  localparam int CLK = 10;

  logic clk = 0, rst_n = 0;
  logic addr_wr = 0, cnt_wr = 0, cmd_wr = 0, irq_en = 1;
  logic [23:0] addr_in = '0;
  logic [15:0] cnt_in = '0;
  logic [1:0]  cmd_op = '0;
  logic mem_rvalid = 0, tx_rdy = 0;
  logic [7:0] mem_rdata = '0;
  logic mem_req, tx_valid, tx_idle, cmd_pending, stat_valid, tx_irq;
  logic [23:0] mem_addr, cur_addr;
  logic [15:0] cur_cnt;
  logic [7:0]  tx_data;

  txdma_seq uut (.*);

  always #(CLK/2) clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0, lat_cfg = 0, stall_cfg = 1, mcnt = 0, rx_n = 0, rx_bad = 0;
  logic [23:0] rx_base = '0;
  bit finished = 0;

  function automatic logic [7:0] pat(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (mem_rvalid) begin
      mem_rvalid = 0;
      mcnt = 0;
    end else if (mem_req) begin
      if (mcnt >= lat_cfg) begin
        mem_rvalid = 1;
        mem_rdata  = pat(mem_addr);
      end else mcnt++;
    end
    tx_rdy = (cyc % stall_cfg) == 0;
    if (tx_valid && tx_rdy) begin
      if (tx_data !== pat(rx_base + 24'(rx_n))) rx_bad++;
      rx_n++;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_addr(logic [23:0] a);
    @(negedge clk); addr_wr = 1; addr_in = a;
    @(negedge clk); addr_wr = 0;
  endtask

  task automatic wr_cnt(logic [15:0] c);
    @(negedge clk); cnt_wr = 1; cnt_in = c;
    @(negedge clk); cnt_wr = 0;
  endtask

  task automatic post(logic [1:0] op);
    @(negedge clk); cmd_wr = 1; cmd_op = op;
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000; i++) begin
      if (tx_idle && !cmd_pending) break;
      @(negedge clk);
    end
  endtask

  task automatic start(logic [23:0] a, logic [15:0] c);
    rx_n = 0; rx_bad = 0; rx_base = a;
    wr_addr(a); wr_cnt(c); post(2'b01);
  endtask

  // addr[55:32] count[31:16] stall[15:8] latency[7:0]
  localparam logic [55:0] VEC [4] = '{
    {24'h000100, 16'd4, 8'd1, 8'd0},
    {24'h0A0F00, 16'd7, 8'd2, 8'd1},
    {24'hFFFFFE, 16'd5, 8'd1, 8'd3},
    {24'h123450, 16'd1, 8'd4, 8'd2}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 idle", 32'(tx_idle), 1);
    chk("R1 pending", 32'(cmd_pending), 0);
    chk("R1 stat_valid", 32'(stat_valid), 1);
    chk("R1 irq", 32'(tx_irq), 0);
    chk("R1 addr", 32'(cur_addr), 0);
    chk("R1 cnt", 32'(cur_cnt), 0);
    chk("R1 bus quiet", 32'({mem_req, tx_valid}), 0);

    foreach (VEC[k]) begin
      logic [23:0] a = VEC[k][55:32];
      logic [15:0] c = VEC[k][31:16];
      stall_cfg = int'(VEC[k][15:8]);
      lat_cfg   = int'(VEC[k][7:0]);
      start(a, c);
      wait_done();
      chk("R8 end addr", 32'(cur_addr), 32'(24'(a + 24'(c))));
      chk("R8 end cnt", 32'(cur_cnt), 0);
      chk("R5 bytes sent", 32'(rx_n), 32'(c));
      chk("R7 R6 byte order/data", 32'(rx_bad), 0);
      chk("R10 irq set", 32'(tx_irq), 1);
      post(2'b10);
      wait_done();
      chk("R10 irq cleared", 32'(tx_irq), 0);
    end
    stall_cfg = 1; lat_cfg = 0;

    // R9 zero count
    start(24'h123456, 16'd0);
    wait_done();
    chk("R9 addr unchanged", 32'(cur_addr), 32'h123456);
    chk("R9 no bytes", 32'(rx_n), 0);
    chk("R9 irq", 32'(tx_irq), 1);
    post(2'b10); wait_done();

    // R10 interrupt disabled
    irq_en = 0;
    start(24'h000200, 16'd2);
    wait_done();
    chk("R10 no irq when disabled", 32'(tx_irq), 0);
    chk("R10 transfer still ran", 32'(cur_addr), 32'h000202);
    irq_en = 1;

    // R4 only the address loaded: command has no effect
    rx_n = 0;
    wr_addr(24'h004000); post(2'b01);
    wait_done();
    repeat (3) @(negedge clk);
    chk("R4 no transfer bytes", 32'(rx_n), 0);
    chk("R4 addr unchanged", 32'(cur_addr), 32'h004000);
    chk("R4 no irq", 32'(tx_irq), 0);

    // R2 R3 R11 activity during a running transfer
    stall_cfg = 3;
    start(24'h003000, 16'd6);
    for (int i = 0; i < 100 && !mem_req; i++) @(negedge clk);
    chk("R11 busy during transfer", 32'(tx_idle), 0);
    wr_addr(24'hABCDEF);
    post(2'b01);
    chk("R3 pending set", 32'(cmd_pending), 1);
    chk("R3 status invalid", 32'(stat_valid), 0);
    post(2'b10);
    wait_done();
    chk("R2 write ignored while busy", 32'(cur_addr), 32'h003006);
    chk("R3 second command dropped", 32'(tx_irq), 1);
    chk("R3 pending cleared", 32'(cmd_pending), 0);
    chk("R4 re-posted command moved nothing", 32'(rx_n), 6);
    chk("R11 idle after transfer", 32'(tx_idle), 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule